// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block produces the read-side timing of a clocked burst interface to a word-organised memory. A 16-bit configuration register sets the read type, the first-access latency, the ready polarity timing and the burst length. It is written by a two-step command sequence on a small command port, with the value taken from the low address bits.

When an address-latch strobe arrives in synchronous mode, the block captures the start address and counts down the programmed latency. It then presents one word per clock from an external word source, indexed by its internal address counter. The counter moves forward only while the advance input is high and the current word is not the last of its aligned block.

Only linear bursts without wrap are supported. A burst stops at the boundary aligned to the burst length and stays quiet until the next latch strobe. A ready output reports when valid data is, or is about to be, on the bus. In one mode it tracks the valid strobe. In the other it leads the valid strobe by one clock.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset the configuration equals 16'h8000 (asynchronous read type), and `word_vld` and `rdy` are low.
- R2: A command write of 8'h60 arms the loader. If the next command write carries 8'h03, the configuration is loaded from `addr_in[15:0]`. Any other next command write disarms the loader without a load, and a lone 8'h03 is ignored.
- R3: While configuration bit 15 is 1 (asynchronous), a latch strobe starts no burst and ends any burst in progress. `word_vld` and `rdy` stay low until a later latch strobe in synchronous mode (bit 15 = 0).
- R4: With latency code L in configuration bits 13:11 (0..7), a latch strobe sampled at clock edge e0 makes the first word valid right after edge e0+L+1.
- R5: Burst length code B in bits 2:0 gives a block of 2^min(B,3) words. The burst presents addresses start, start+1, ... up to the last address of the aligned block containing start, so it delivers len - (start mod len) words. Then `word_vld` drops and stays low.
- R6: The address counter steps only at an edge where `word_vld` and `adv` are both high. With `adv` low the same address and word stay on the outputs.
- R7: With bit 8 = 0, `rdy` equals `word_vld` in every cycle.
- R8: With bit 8 = 1, `rdy` is high in the cycle just before the first valid word and during every valid word except the last word of the block, where it is low.
- R9: A latch strobe in synchronous mode during a burst restarts the sequence from the new address with fresh latency timing.
- R10: `word_data` equals `src_data` while `word_vld` is high, and configuration bit 3 (wrap request) has no effect on the word sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command code |
| addr_in | input | ADDR_W | Start address on latch; configuration value in low 16 bits on load |
| lat_stb | input | 1 | Address latch strobe |
| adv | input | 1 | Advance request, high = step to next word |
| src_data | input | DATA_W | Word returned by the source for `word_addr` |
| word_addr | output | ADDR_W | Internal address counter, index into word source |
| word_data | output | DATA_W | Word presented to the bus |
| word_vld | output | 1 | Current word is valid |
| rdy | output | 1 | Data-ready indication |

## Verification
The bench sweeps every latency code against every length code in both ready modes. It uses start offsets that put the first word at, inside and at the end of an aligned block. An off-by-one in the latency counter would shift every first word by a cycle. A boundary test done on the wrong side would leak one word past the block end or drop the last one. Stalling `adv` in a fixed pattern catches a counter that steps without a grant. The early-ready mode catches a ready that falls one cycle too late at the block end. A broken command sequence, a restart mid-burst and a latch while asynchronous target a loader that arms too loosely and a sequencer that keeps bursting after it should have stopped.

// File: rtl/brs_pkg.sv
package brs_pkg;

   localparam int CFG_W        = 16;
   localparam int CMD_W        = 8;
   localparam int LAT_W        = 3;
   localparam int BL_W         = 3;

   localparam int CFG_ASYNC_B  = 15;
   localparam int CFG_LAT_HI   = 13;
   localparam int CFG_LAT_LO   = 11;
   localparam int CFG_EARLY_B  = 8;
   localparam int CFG_BL_HI    = 2;
   localparam int CFG_BL_LO    = 0;

   localparam logic [CMD_W-1:0] CMD_ARM  = 8'h60;
   localparam logic [CMD_W-1:0] CMD_LOAD = 8'h03;
   localparam logic [CFG_W-1:0] CFG_RST  = 16'h8000;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_WAIT  = 2'd1,
      SQ_BURST = 2'd2,
      SQ_DONE  = 2'd3
   } sq_state_e;

   typedef struct packed {
      logic              async_rd;
      logic [LAT_W-1:0]  lat;
      logic              early;
      logic [BL_W-1:0]   bl;
   } cfg_view_t;

   function automatic cfg_view_t cfg_decode(input logic [CFG_W-1:0] c);
      cfg_view_t v;
      v.async_rd = c[CFG_ASYNC_B];
      v.lat      = c[CFG_LAT_HI:CFG_LAT_LO];
      v.early    = c[CFG_EARLY_B];
      v.bl       = c[CFG_BL_HI:CFG_BL_LO];
      return v;
   endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
   import brs_pkg::*;
#(
   parameter int                 REG_W   = CFG_W,
   parameter int                 OP_W    = CMD_W,
   parameter logic [REG_W-1:0]   RST_VAL = CFG_RST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [OP_W-1:0]   cmd_data,
   input  logic [REG_W-1:0]  load_val,
   output logic [REG_W-1:0]  cfg_q
);

   initial begin
      assert (REG_W >= CFG_W) else $error("REG_W too narrow for field map");
      assert (OP_W >= CMD_W)  else $error("OP_W too narrow for command codes");
   end

   logic armed_q;
   logic is_arm;
   logic is_load;

   assign is_arm  = (cmd_data == OP_W'(CMD_ARM));
   assign is_load = (cmd_data == OP_W'(CMD_LOAD));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cfg_q   <= RST_VAL;
      end else if (cmd_we) begin
         if (armed_q) begin
            armed_q <= 1'b0;
            if (is_load) cfg_q <= load_val;
         end else begin
            armed_q <= is_arm;
         end
      end
   end

   AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && armed_q && is_load) |=> (cfg_q == $past(load_val))); // R2
   AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_we && armed_q) |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/brs_addr_ctr.sv
module brs_addr_ctr
   import brs_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int MAX_LEN_LOG2 = 3,
   parameter int CODE_W       = BL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [CODE_W-1:0] bl_code,
   input  logic              step,
   output logic [ADDR_W-1:0] addr_q,
   output logic              at_last
);

   localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(MAX_LEN_LOG2);

   initial begin
      assert (MAX_LEN_LOG2 < ADDR_W)         else $error("burst block wider than address");
      assert (MAX_LEN_LOG2 < (1 << CODE_W))  else $error("length code cannot reach maximum");
   end

   logic [CODE_W-1:0] bl_q;
   logic [ADDR_W-1:0] mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         bl_q   <= '0;
      end else if (load) begin
         addr_q <= load_addr;
         bl_q   <= bl_code;
      end else if (step) begin
         addr_q <= addr_q + ADDR_W'(1);
      end
   end

   generate
      if (MAX_LEN_LOG2 == 0) begin : g_single
         logic bl_q_unused;
         assign bl_q_unused = ^bl_q;
         assign mask        = '0;
         assign at_last     = 1'b1;
      end else begin : g_block
         logic [CODE_W-1:0] len_log;
         assign len_log = (bl_q > MAX_CODE) ? MAX_CODE : bl_q;
         assign mask    = (ADDR_W'(1) << len_log) - ADDR_W'(1);
         assign at_last = ((addr_q & mask) == mask);
      end
   endgenerate

   AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(addr_q)); // R6
   AST_STAY_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> ((addr_q & ~mask) == ($past(addr_q) & ~$past(mask)))); // R5

endmodule

// File: rtl/brs_seq_fsm.sv
module brs_seq_fsm
   import brs_pkg::*;
#(
   parameter int CNT_W = LAT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lat_go,
   input  logic             lat_abort,
   input  logic [CNT_W-1:0] lat_code,
   input  logic             early_in,
   input  logic             adv,
   input  logic             at_last,
   output logic             load,
   output logic             step,
   output logic             word_vld,
   output logic             rdy
);

   initial begin
      assert (CNT_W >= 1) else $error("latency counter needs a bit");
   end

   sq_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             early_q;
   logic             wait_end;

   assign wait_end = (st_q == SQ_WAIT) && (cnt_q == '0);
   assign word_vld = (st_q == SQ_BURST);
   assign load     = lat_go;
   assign step     = word_vld && adv && !at_last;
   assign rdy      = early_q ? (wait_end || (word_vld && !at_last)) : word_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         cnt_q   <= '0;
         early_q <= 1'b0;
      end else if (lat_abort) begin
         st_q    <= SQ_IDLE;
      end else if (lat_go) begin
         st_q    <= SQ_WAIT;
         cnt_q   <= lat_code;
         early_q <= early_in;
      end else begin
         unique case (st_q)
            SQ_WAIT: begin
               if (cnt_q == '0) st_q  <= SQ_BURST;
               else             cnt_q <= cnt_q - CNT_W'(1);
            end
            SQ_BURST: begin
               if (adv && at_last) st_q <= SQ_DONE;
            end
            default: st_q <= st_q;
         endcase
      end
   end

   AST_EARLY_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (early_q && rdy && !word_vld && !lat_go && !lat_abort) |=> word_vld); // R8
   AST_END_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && adv && at_last && !lat_go && !lat_abort) |=> !word_vld); // R5
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      lat_abort |=> (!word_vld && !rdy)); // R3
   AST_GO_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      lat_go |=> !word_vld); // R4

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
   import brs_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int DATA_W       = 32,
   parameter int MAX_LEN_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [7:0]        cmd_data,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              lat_stb,
   input  logic              adv,
   input  logic [DATA_W-1:0] src_data,
   output logic [ADDR_W-1:0] word_addr,
   output logic [DATA_W-1:0] word_data,
   output logic              word_vld,
   output logic              rdy
);

   initial begin
      assert (ADDR_W >= CFG_W) else $error("address bus narrower than configuration value");
      assert (DATA_W >= 1)     else $error("DATA_W must be positive");
   end

   logic [CFG_W-1:0] cfg_q;
   cfg_view_t        cfg_v;
   logic             lat_go;
   logic             lat_abort;
   logic             load;
   logic             step;
   logic             at_last;
   logic             cfg_spare_unused;

   assign cfg_v            = cfg_decode(cfg_q);
   assign cfg_spare_unused = ^{cfg_q[14], cfg_q[10:9], cfg_q[7:3]};
   assign lat_go           = lat_stb && !cfg_v.async_rd;
   assign lat_abort        = lat_stb &&  cfg_v.async_rd;

   brs_cfg_reg #(
      .REG_W   (CFG_W),
      .OP_W    (CMD_W),
      .RST_VAL (CFG_RST)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (cmd_we),
      .cmd_data (cmd_data),
      .load_val (addr_in[CFG_W-1:0]),
      .cfg_q    (cfg_q)
   );

   brs_seq_fsm #(
      .CNT_W (LAT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .lat_go    (lat_go),
      .lat_abort (lat_abort),
      .lat_code  (cfg_v.lat),
      .early_in  (cfg_v.early),
      .adv       (adv),
      .at_last   (at_last),
      .load      (load),
      .step      (step),
      .word_vld  (word_vld),
      .rdy       (rdy)
   );

   brs_addr_ctr #(
      .ADDR_W       (ADDR_W),
      .MAX_LEN_LOG2 (MAX_LEN_LOG2),
      .CODE_W       (BL_W)
   ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (addr_in),
      .bl_code   (cfg_v.bl),
      .step      (step),
      .addr_q    (word_addr),
      .at_last   (at_last)
   );

   assign word_data = src_data;

   AST_RDY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_v.early && lat_go) |=> (rdy == word_vld)); // R7

endmodule

// File: tb/burst_rd_seq_test.sv
`timescale 1ns/100ps
module burst_rd_seq_test;

   localparam int AW = 20;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_we = 1'b0;
   logic [7:0]    cmd_data = '0;
   logic [AW-1:0] addr_in = '0;
   logic          lat_stb = 1'b0;
   logic          adv = 1'b1;
   logic [DW-1:0] src_data;
   logic [AW-1:0] word_addr;
   logic [DW-1:0] word_data;
   logic          word_vld;
   logic          rdy;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   assign src_data = {12'hA5C, word_addr};

   burst_rd_seq #(.ADDR_W(AW), .DATA_W(DW), .MAX_LEN_LOG2(3)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
      .addr_in(addr_in), .lat_stb(lat_stb), .adv(adv), .src_data(src_data),
      .word_addr(word_addr), .word_data(word_data), .word_vld(word_vld), .rdy(rdy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic write_cmd(input logic [7:0] op, input logic [AW-1:0] a);
      cmd_we = 1'b1; cmd_data = op; addr_in = a;
      @(negedge clk);
      cmd_we = 1'b0;
   endtask

   task automatic set_cfg(input logic [15:0] v);
      write_cmd(8'h60, '0);
      write_cmd(8'h03, AW'(v));
   endtask

   function automatic logic [15:0] mk_cfg(input int lat, input int bl, input bit early,
                                          input bit wrap);
      logic [15:0] c;
      c = '0;
      c[13:11] = lat[2:0];
      c[8]     = early;
      c[3]     = wrap;
      c[2:0]   = bl[2:0];
      return c;
   endfunction

   // Latch at the current negedge, then compare every cycle against the arithmetic
   // expectation. stall selects an adv pattern; cut stops early (0 = run to the end).
   task automatic run_burst(input logic [AW-1:0] start, input int lat, input int bl,
                            input bit early, input bit stall, input int cut,
                            input string req);
      int len;
      int nw;
      int idx;
      bit fin;
      int total;
      len = 1 << ((bl > 3) ? 3 : bl);
      nw  = len - int'(start % AW'(len));
      idx = 0;
      fin = 1'b0;
      total = (cut > 0) ? cut : lat + 1 + 3 * nw + 3;
      lat_stb = 1'b1; addr_in = start; adv = 1'b1;
      for (int m = 0; m < total; m++) begin
         bit ev;
         bit er;
         @(negedge clk);
         lat_stb = 1'b0;
         ev = (m >= lat + 1) && !fin;
         if (early) er = (m == lat) || (ev && idx != nw - 1);
         else       er = ev;
         check(word_vld == ev, req, "word_vld", word_vld, ev);
         check(rdy == er, early ? "R8" : "R7", "rdy", rdy, er);
         if (ev) begin
            check(word_addr == start + AW'(idx), "R5", "word_addr", word_addr, start + AW'(idx));
            check(word_data == {12'hA5C, start + AW'(idx)}, "R10", "word_data",
                  word_data, {12'hA5C, start + AW'(idx)});
         end
         adv = stall ? ((m % 3) != 1) : 1'b1;
         if (ev && adv) begin
            if (idx == nw - 1) fin = 1'b1;
            else               idx++;
         end
      end
      adv = 1'b1;
   endtask

   task automatic idle_check(input logic [AW-1:0] start, input int cycles, input string req);
      lat_stb = 1'b1; addr_in = start;
      for (int m = 0; m < cycles; m++) begin
         @(negedge clk);
         lat_stb = 1'b0;
         check(word_vld == 1'b0, req, "word_vld idle", word_vld, 0);
         check(rdy == 1'b0, req, "rdy idle", rdy, 0);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual expired expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle outputs after reset
      check(word_vld == 1'b0, "R1", "word_vld after reset", word_vld, 0);
      check(rdy == 1'b0, "R1", "rdy after reset", rdy, 0);
      // R1 / R3: default is asynchronous, so a latch yields nothing
      idle_check(20'h00400, 12, "R1");

      // R4 R5 R7 R8 R10: full sweep of latency, length, ready mode, wrap bit
      for (int e = 0; e < 2; e++) begin
         for (int l = 0; l < 8; l++) begin
            for (int b = 0; b < 8; b++) begin
               logic [AW-1:0] st;
               st = 20'h12340 + AW'((l * 3 + b) % 8);
               set_cfg(mk_cfg(l, b, e[0], l[0]));
               run_burst(st, l, b, e[0], 1'b0, 0, "R4");
            end
         end
      end

      // R6: adv stall pattern, both ready modes
      set_cfg(mk_cfg(1, 3, 1'b0, 1'b0));
      run_burst(20'h00100, 1, 3, 1'b0, 1'b1, 0, "R6");
      set_cfg(mk_cfg(2, 2, 1'b1, 1'b0));
      run_burst(20'h00105, 2, 2, 1'b1, 1'b1, 0, "R6");

      // R9: restart mid-burst
      set_cfg(mk_cfg(2, 3, 1'b0, 1'b0));
      run_burst(20'h00200, 2, 3, 1'b0, 1'b0, 5, "R9");
      run_burst(20'h00333, 2, 3, 1'b0, 1'b0, 0, "R9");

      // R2: broken sequence leaves configuration (latency 2) unchanged
      write_cmd(8'h60, '0);
      write_cmd(8'h90, '0);
      write_cmd(8'h03, AW'(mk_cfg(5, 1, 1'b0, 1'b0)));
      run_burst(20'h00400, 2, 3, 1'b0, 1'b0, 0, "R2");
      // R2: lone load code ignored
      write_cmd(8'h03, AW'(mk_cfg(6, 0, 1'b1, 1'b0)));
      run_burst(20'h00410, 2, 3, 1'b0, 1'b0, 0, "R2");

      // R3: switch to asynchronous mid-burst, latch ends burst
      run_burst(20'h00500, 2, 3, 1'b0, 1'b0, 4, "R3");
      set_cfg(16'h8000 | mk_cfg(0, 3, 1'b0, 1'b0));
      idle_check(20'h00508, 12, "R3");

      // R1: reset restores asynchronous default
      set_cfg(mk_cfg(0, 2, 1'b0, 1'b0));
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      idle_check(20'h00600, 10, "R1");

      finish_run();
   end

endmodule